// File: doc/BRIEF.md
# USB Device Handshake Response Controller

This block sits behind the token decoder of a low-speed USB device and picks the answer to every transaction. A SETUP or OUT token is remembered. The data packet that follows is either ignored, refused with NAK, acknowledged without being kept, or accepted. An accepted packet latches its length and the remembered token, then flips a two-half receive buffer. An IN token gets one of three answers:
- NAK, when received data is still waiting for the firmware;
- a handshake PID held in the endpoint's transmit slot;
- a data packet from that endpoint's buffer.

The controller emits its answer as a one-cycle command strobe to the transmitter. The command carries a kind code, a byte and an endpoint select. Because the strobe comes out one clock after the decoded input, the reply starts well inside the 7.5 bit-time turnaround window. The firmware side is reduced to a few write pulses: set the receive length (0 releases the buffer, a negative value acts as flow control), load a transmit slot, and stage a new device address. A staged address becomes active only when a data packet goes out.

Top module: `usbhs_resp`

## Requirements
- R1: A SETUP token stores marker 1. An OUT token with `tok_ep_hi`=0 stores marker 2, and with `tok_ep_hi`=1 stores marker 3. The stored marker is copied to `rx_tok` when a data packet is accepted. `tok_kind` codes: 0 SETUP, 1 OUT, 2 IN. `reply_kind` codes: 0 ACK, 1 NAK, 2 PID, 3 DATA.
- R2: A data packet that arrives while no marker is stored (marker 0, the state after reset) produces no strobe and changes no state.
- R3: A data packet that arrives while a marker is stored and `rx_len` is non-zero (positive or negative) is answered with kind NAK and code 0x5A, and the receive state is left unchanged.
- R4: A data packet with a marker stored, `rx_len` = 0 and `data_len` < 4 is answered with kind ACK and code 0xD2. It is not stored: `rx_len` stays 0 and `rx_ofs` does not change.
- R5: A data packet with a marker stored, `rx_len` = 0 and `data_len` ≥ 4 is answered with ACK (0xD2). It sets `rx_len` to `data_len`, `rx_tok` to the marker, and `rx_ofs` to BUF_SIZE minus the old `rx_ofs`.
- R6: An IN token while `rx_len` is 1 or more (signed) is answered with kind NAK, code 0x5A and `reply_ep` set to the selected endpoint. It leaves the transmit slot untouched.
- R7: An IN token while `rx_len` ≤ 0, on a slot whose bit 4 is set, is answered with kind PID and the slot byte as code. The slot keeps its value.
- R8: An IN token while `rx_len` ≤ 0, on a slot whose bit 4 is clear, is answered with kind DATA and the slot byte as code. The slot then holds 0x5A at once.
- R9: The endpoint select is 0 when `tok_ep_hi`=0, 1 when `tok_ep_hi`=1 and `tok_ep_alt`=0, and 2 (the third endpoint) when both are 1. Firmware loads slot n through `fw_tx_sel`=n.
- R10: `dev_addr` takes the staged address only in the cycle a DATA reply is issued, never on an ACK, NAK or PID reply.
- R11: `reply_stb` rises on the clock edge after the `tok_valid` or `data_valid` cycle that causes it and stays high for exactly one cycle.
- R12: After reset there is no strobe, `rx_len`, `rx_tok`, `rx_ofs` and `dev_addr` are 0, and every transmit slot holds 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_kind | input | 2 | Token type: 0 SETUP, 1 OUT, 2 IN |
| tok_ep_hi | input | 1 | Token addresses a non-zero endpoint |
| tok_ep_alt | input | 1 | Non-zero endpoint is the third one |
| data_valid | input | 1 | Data packet received this cycle |
| data_len | input | LEN_W | Byte count of the data packet including PID and CRC |
| fw_rx_wr | input | 1 | Firmware writes the receive length |
| fw_rx_val | input | LEN_W | Value for the receive length (signed) |
| fw_tx_wr | input | 1 | Firmware loads a transmit slot |
| fw_tx_sel | input | 2 | Slot to load |
| fw_tx_val | input | 8 | Slot byte (length or handshake PID) |
| fw_addr_wr | input | 1 | Firmware stages a new device address |
| fw_addr_val | input | ADDR_W | Staged address |
| reply_stb | output | 1 | One-cycle reply command strobe |
| reply_kind | output | 2 | 0 ACK, 1 NAK, 2 PID, 3 DATA |
| reply_code | output | 8 | Handshake PID or slot byte |
| reply_ep | output | 2 | Endpoint select for IN replies, 0 otherwise |
| rx_len | output | LEN_W | Receive length register (signed) |
| rx_tok | output | 2 | Marker of the last accepted packet |
| rx_ofs | output | OFS_W | Offset of the current input half of the buffer |
| dev_addr | output | ADDR_W | Active device address |

## Verification
The assertions assume three things about the inputs: a token and a data packet never arrive in the same cycle, and no firmware write to the receive length or address lands in the same cycle as a transaction. The bench honours all three. Each transaction and each firmware write takes its own clock cycle, with idle inputs between them. The bench sweeps every stored marker against zero, positive and negative receive lengths and a range of packet lengths. It also sweeps IN tokens across all three endpoints, signed receive lengths and both slot types.

// File: rtl/usbhs_pkg.sv
package usbhs_pkg;
  typedef enum logic [1:0] {TOK_SETUP = 2'd0, TOK_OUT = 2'd1, TOK_IN = 2'd2, TOK_RSVD = 2'd3} tok_kind_e;
  typedef enum logic [1:0] {RTOK_NONE = 2'd0, RTOK_SETUP = 2'd1, RTOK_OUT0 = 2'd2, RTOK_OUTN = 2'd3} rtok_e;
  typedef enum logic [1:0] {RPL_ACK = 2'd0, RPL_NAK = 2'd1, RPL_PID = 2'd2, RPL_DATA = 2'd3} rpl_e;
  localparam logic [7:0] PID_ACK  = 8'hD2;
  localparam logic [7:0] PID_NAK  = 8'h5A;
  localparam int         HS_BIT   = 4;
  localparam int         DATA_MIN = 4;
endpackage

// File: rtl/usbhs_rx_ctl.sv
module usbhs_rx_ctl
  import usbhs_pkg::*;
#(
  parameter int BUF_SIZE = 11,
  parameter int LEN_W    = 8,
  parameter int OFS_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tok_set,
  input  logic [1:0]       tok_mark,
  input  logic             data_valid,
  input  logic [LEN_W-1:0] data_len,
  input  logic             fw_rx_wr,
  input  logic [LEN_W-1:0] fw_rx_val,
  output logic             data_fire,
  output logic             data_nak,
  output logic             in_block,
  output logic [LEN_W-1:0] rx_len,
  output logic [1:0]       rx_tok,
  output logic [OFS_W-1:0] rx_ofs,
  output logic [1:0]       cur_tok
);
  logic accept;

  always_comb begin
    data_fire = data_valid && (cur_tok != RTOK_NONE);
    data_nak  = (rx_len != '0);
    accept    = data_fire && !data_nak && (data_len >= LEN_W'(DATA_MIN));
    // positive length means unread data: IN must wait
    in_block  = !rx_len[LEN_W-1] && (rx_len != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_tok <= RTOK_NONE;
      rx_len  <= '0;
      rx_tok  <= RTOK_NONE;
      rx_ofs  <= '0;
    end else begin
      if (tok_set) cur_tok <= tok_mark;
      if (accept) begin
        rx_len <= data_len;
        rx_tok <= cur_tok;
        rx_ofs <= OFS_W'(BUF_SIZE) - rx_ofs;
      end else if (fw_rx_wr) begin
        rx_len <= fw_rx_val;
      end
    end
  end
endmodule

// File: rtl/usbhs_tx_slots.sv
module usbhs_tx_slots
  import usbhs_pkg::*;
#(
  parameter int NUM_EP = 3,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_go,
  input  logic [SEL_W-1:0] in_sel,
  input  logic             fw_wr,
  input  logic [SEL_W-1:0] fw_sel,
  input  logic [7:0]       fw_val,
  output logic [7:0]       slot_val,
  output logic             slot_hs
);
  logic [NUM_EP*8-1:0] slot_flat;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= PID_NAK;
      end else if (in_go && in_sel == SEL_W'(i) && !q[HS_BIT]) begin
        q <= PID_NAK;  // data leaves: slot falls back to NAK immediately
      end else if (fw_wr && fw_sel == SEL_W'(i)) begin
        q <= fw_val;
      end
    end
    assign slot_flat[i*8 +: 8] = q;
  end

  always_comb begin
    slot_val = PID_NAK;
    for (int i = 0; i < NUM_EP; i++)
      if (in_sel == SEL_W'(i)) slot_val = slot_flat[i*8 +: 8];
    slot_hs = slot_val[HS_BIT];
  end
endmodule

// File: rtl/usbhs_resp.sv
module usbhs_resp
  import usbhs_pkg::*;
#(
  parameter int BUF_SIZE = 11,
  parameter int LEN_W    = 8,
  parameter int ADDR_W   = 7,
  parameter int EP3_EN   = 1,
  localparam int NUM_EP  = (EP3_EN != 0) ? 3 : 2,
  localparam int SEL_W   = 2,
  localparam int OFS_W   = $clog2(BUF_SIZE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_valid,
  input  logic [1:0]        tok_kind,
  input  logic              tok_ep_hi,
  input  logic              tok_ep_alt,
  input  logic              data_valid,
  input  logic [LEN_W-1:0]  data_len,
  input  logic              fw_rx_wr,
  input  logic [LEN_W-1:0]  fw_rx_val,
  input  logic              fw_tx_wr,
  input  logic [1:0]        fw_tx_sel,
  input  logic [7:0]        fw_tx_val,
  input  logic              fw_addr_wr,
  input  logic [ADDR_W-1:0] fw_addr_val,
  output logic              reply_stb,
  output logic [1:0]        reply_kind,
  output logic [7:0]        reply_code,
  output logic [1:0]        reply_ep,
  output logic [LEN_W-1:0]  rx_len,
  output logic [1:0]        rx_tok,
  output logic [OFS_W-1:0]  rx_ofs,
  output logic [ADDR_W-1:0] dev_addr
);
  logic             tok_set, in_tok, in_go;
  logic [1:0]       tok_mark;
  logic [SEL_W-1:0] in_sel;
  logic             data_fire, data_nak, in_block;
  logic [1:0]       cur_tok;
  logic [7:0]       slot_val;
  logic             slot_hs;
  logic [ADDR_W-1:0] addr_pend;

  always_comb begin
    tok_set  = tok_valid && (tok_kind == TOK_SETUP || tok_kind == TOK_OUT);
    tok_mark = (tok_kind == TOK_SETUP) ? RTOK_SETUP : (tok_ep_hi ? RTOK_OUTN : RTOK_OUT0);
    in_tok   = tok_valid && (tok_kind == TOK_IN);
    in_sel   = !tok_ep_hi ? 2'd0 : ((EP3_EN != 0 && tok_ep_alt) ? 2'd2 : 2'd1);
    in_go    = in_tok && !in_block;
  end

  usbhs_rx_ctl #(.BUF_SIZE(BUF_SIZE), .LEN_W(LEN_W), .OFS_W(OFS_W)) u_rx (
    .clk(clk), .rst(rst), .tok_set(tok_set), .tok_mark(tok_mark),
    .data_valid(data_valid), .data_len(data_len),
    .fw_rx_wr(fw_rx_wr), .fw_rx_val(fw_rx_val),
    .data_fire(data_fire), .data_nak(data_nak), .in_block(in_block),
    .rx_len(rx_len), .rx_tok(rx_tok), .rx_ofs(rx_ofs), .cur_tok(cur_tok)
  );

  usbhs_tx_slots #(.NUM_EP(NUM_EP), .SEL_W(SEL_W)) u_tx (
    .clk(clk), .rst(rst), .in_go(in_go), .in_sel(in_sel),
    .fw_wr(fw_tx_wr), .fw_sel(fw_tx_sel), .fw_val(fw_tx_val),
    .slot_val(slot_val), .slot_hs(slot_hs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reply_stb  <= 1'b0;
      reply_kind <= RPL_ACK;
      reply_code <= '0;
      reply_ep   <= '0;
      addr_pend  <= '0;
      dev_addr   <= '0;
    end else begin
      reply_stb <= 1'b0;
      if (fw_addr_wr) addr_pend <= fw_addr_val;
      if (data_fire) begin
        reply_stb  <= 1'b1;
        reply_kind <= data_nak ? RPL_NAK : RPL_ACK;
        reply_code <= data_nak ? PID_NAK : PID_ACK;
        reply_ep   <= '0;
      end else if (in_tok) begin
        reply_stb <= 1'b1;
        reply_ep  <= in_sel;
        if (in_block) begin
          reply_kind <= RPL_NAK;
          reply_code <= PID_NAK;
        end else if (slot_hs) begin
          reply_kind <= RPL_PID;
          reply_code <= slot_val;
        end else begin
          reply_kind <= RPL_DATA;
          reply_code <= slot_val;
          dev_addr   <= addr_pend;
        end
      end
    end
  end
endmodule

// File: rtl/usbhs_resp_chk.sv
module usbhs_resp_chk #(
  parameter int BUF_SIZE = 11,
  parameter int LEN_W    = 8,
  parameter int ADDR_W   = 7,
  parameter int OFS_W    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tok_valid,
  input logic [1:0]        tok_kind,
  input logic              data_valid,
  input logic [LEN_W-1:0]  data_len,
  input logic              reply_stb,
  input logic [1:0]        reply_kind,
  input logic [7:0]        reply_code,
  input logic [LEN_W-1:0]  rx_len,
  input logic [OFS_W-1:0]  rx_ofs,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [1:0]        cur_tok
);
  // R11
  reply_latency_chk: assert property (@(posedge clk) disable iff (rst)
    reply_stb |-> $past(tok_valid || data_valid));
  // R2
  data_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (data_valid && cur_tok == 2'd0) |=> !reply_stb);
  // R3
  data_busy_nak_chk: assert property (@(posedge clk) disable iff (rst)
    (data_valid && cur_tok != 2'd0 && rx_len != '0) |=>
      (reply_stb && reply_kind == 2'd1 && reply_code == 8'h5A));
  // R4
  short_pkt_chk: assert property (@(posedge clk) disable iff (rst)
    (data_valid && cur_tok != 2'd0 && rx_len == '0 && data_len < LEN_W'(4)) |=>
      (reply_stb && reply_kind == 2'd0 && $stable(rx_ofs) && rx_len == '0));
  // R5
  ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ofs == '0) || (rx_ofs == OFS_W'(BUF_SIZE)));
  // R6
  in_block_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && tok_kind == 2'd2 && !rx_len[LEN_W-1] && rx_len != '0) |=>
      (reply_stb && reply_kind == 2'd1));
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dev_addr) |-> (reply_stb && reply_kind == 2'd3));
endmodule

bind usbhs_resp usbhs_resp_chk #(
  .BUF_SIZE(BUF_SIZE), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/usbhs_resp_bench.sv
module usbhs_resp_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic tok_valid = 0, tok_ep_hi = 0, tok_ep_alt = 0, data_valid = 0;
  logic [1:0] tok_kind = 0;
  logic [7:0] data_len = 0, fw_rx_val = 0, fw_tx_val = 0;
  logic fw_rx_wr = 0, fw_tx_wr = 0, fw_addr_wr = 0;
  logic [1:0] fw_tx_sel = 0;
  logic [6:0] fw_addr_val = 0;
  logic reply_stb;
  logic [1:0] reply_kind, reply_ep, rx_tok;
  logic [7:0] reply_code, rx_len;
  logic [3:0] rx_ofs;
  logic [6:0] dev_addr;

  int total = 0, bad = 0;
  bit done = 0;

  logic signed [7:0] m_rxlen;
  int m_ofs, m_rtok, m_cur;
  logic [7:0] m_slot [3];

  always #5 clk = ~clk;

  usbhs_resp u_usbhs_resp (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic fw_rx(input logic [7:0] v);
    @(negedge clk); fw_rx_wr = 1; fw_rx_val = v;
    @(negedge clk); fw_rx_wr = 0;
  endtask

  task automatic fw_tx(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk); fw_tx_wr = 1; fw_tx_sel = s; fw_tx_val = v;
    @(negedge clk); fw_tx_wr = 0;
  endtask

  task automatic fw_addr(input logic [6:0] v);
    @(negedge clk); fw_addr_wr = 1; fw_addr_val = v;
    @(negedge clk); fw_addr_wr = 0;
  endtask

  // one transaction; reply expected one edge later, gone the edge after (R11)
  task automatic xact(input logic tv, input logic [1:0] tk, input logic eh, input logic ea,
                      input logic dv, input logic [7:0] dl, input bit es,
                      input logic [1:0] ek, input logic [7:0] ec, input logic [1:0] ee,
                      input string rq);
    @(negedge clk);
    tok_valid = tv; tok_kind = tk; tok_ep_hi = eh; tok_ep_alt = ea;
    data_valid = dv; data_len = dl;
    @(negedge clk);
    tok_valid = 0; data_valid = 0;
    chk(reply_stb == es, rq, reply_stb, es);
    if (es) begin
      chk(reply_kind == ek, rq, reply_kind, ek);
      chk(reply_code == ec, rq, reply_code, ec);
      chk(reply_ep == ee, rq, reply_ep, ee);
    end
    @(negedge clk);
    chk(reply_stb == 0, "R11 single-cycle strobe", reply_stb, 0);
  endtask

  task automatic chk_rx(input string rq);
    chk(rx_len == m_rxlen, rq, rx_len, m_rxlen);
    chk(rx_ofs == m_ofs, rq, rx_ofs, m_ofs);
    chk(rx_tok == m_rtok, rq, rx_tok, m_rtok);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    m_rxlen = 0; m_ofs = 0; m_rtok = 0; m_cur = 0;
    for (int i = 0; i < 3; i++) m_slot[i] = 8'h5A;
    // R12 reset state
    chk(reply_stb == 0, "R12 stb", reply_stb, 0);
    chk(dev_addr == 0, "R12 addr", dev_addr, 0);
    chk_rx("R12 rx state");
    for (int ep = 0; ep < 3; ep++)
      xact(1, 2, ep != 0, ep == 2, 0, 0, 1, 2, 8'h5A, 2'(ep), "R12 slot reset NAK");

    // R2 no marker stored: silence
    for (int l = 0; l < 8; l++) begin
      xact(0, 0, 0, 0, 1, 8'(l), 0, 0, 0, 0, "R2 no token silent");
      chk_rx("R2 state unchanged");
    end

    // R1 R3 R4 R5 data sweep
    for (int t = 1; t < 4; t++) begin
      xact(1, (t == 1) ? 2'd0 : 2'd1, t == 3, 0, 0, 0, 0, 0, 0, 0, "R1 token silent");
      m_cur = t;
      for (int n = 0; n < 3; n++) begin
        for (int l = 2; l < 7; l++) begin
          logic [7:0] rv;
          rv = (n == 0) ? 8'h00 : (n == 1) ? 8'h05 : 8'hFF;
          fw_rx(rv); m_rxlen = rv;
          if (m_rxlen != 0) begin
            xact(0, 0, 0, 0, 1, 8'(l), 1, 1, 8'h5A, 0, "R3 busy NAK");
            chk_rx("R3 state kept");
          end else if (l < 4) begin
            xact(0, 0, 0, 0, 1, 8'(l), 1, 0, 8'hD2, 0, "R4 short ACK");
            chk_rx("R4 not stored");
          end else begin
            xact(0, 0, 0, 0, 1, 8'(l), 1, 0, 8'hD2, 0, "R5 accept ACK");
            m_rxlen = 8'(l); m_rtok = m_cur; m_ofs = 11 - m_ofs;
            chk_rx("R5 R1 stored and swapped");
          end
        end
      end
    end

    // R6 R7 R8 R9 IN sweep
    for (int r = 0; r < 4; r++)
      for (int ep = 0; ep < 3; ep++)
        for (int s = 0; s < 2; s++) begin
          logic signed [7:0] rv;
          logic [7:0] sv;
          rv = (r == 0) ? -8'sd2 : (r == 1) ? 8'sd0 : (r == 2) ? 8'sd1 : 8'sd7;
          sv = (s == 0) ? 8'h1E : 8'h03;
          fw_tx(2'(ep), sv); m_slot[ep] = sv;
          fw_rx(rv); m_rxlen = rv;
          if (rv > 0) begin
            xact(1, 2, ep != 0, ep == 2, 0, 0, 1, 1, 8'h5A, 2'(ep), "R6 IN blocked NAK");
            xact(1, 2, ep != 0, ep == 2, 0, 0, 1, 1, 8'h5A, 2'(ep), "R6 R9 still blocked");
          end else if (sv[4]) begin
            xact(1, 2, ep != 0, ep == 2, 0, 0, 1, 2, sv, 2'(ep), "R7 R9 handshake PID");
            xact(1, 2, ep != 0, ep == 2, 0, 0, 1, 2, sv, 2'(ep), "R7 slot kept");
          end else begin
            xact(1, 2, ep != 0, ep == 2, 0, 0, 1, 3, sv, 2'(ep), "R8 R9 data sent");
            m_slot[ep] = 8'h5A;
            xact(1, 2, ep != 0, ep == 2, 0, 0, 1, 2, 8'h5A, 2'(ep), "R8 slot back to NAK");
          end
        end

    // R10 address switch only on data
    fw_rx(0);
    fw_addr(7'h2A);
    chk(dev_addr == 0, "R10 staged not active", dev_addr, 0);
    fw_tx(0, 8'h1E);
    xact(1, 2, 0, 0, 0, 0, 1, 2, 8'h1E, 0, "R10 PID reply");
    chk(dev_addr == 0, "R10 no change on PID", dev_addr, 0);
    xact(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 setup silent");
    xact(0, 0, 0, 0, 1, 8'd2, 1, 0, 8'hD2, 0, "R10 ACK reply");
    chk(dev_addr == 0, "R10 no change on ACK", dev_addr, 0);
    fw_tx(1, 8'h04);
    xact(1, 2, 1, 0, 0, 0, 1, 3, 8'h04, 1, "R10 data reply");
    chk(dev_addr == 7'h2A, "R10 active after data", dev_addr, 7'h2A);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule